// File: doc/BRIEF.md
# Microcoded Accumulator Processor

A compact accumulator machine whose every register transfer is issued by a 128-word, 20-bit microcode store held as a constant inside the design. Each microword carries three 3-bit micro-operation fields, a 2-bit condition select, a 2-bit branch kind and a 7-bit target. The sequencer decodes the three fields into a small bundle of strobes for the datapath. It then picks the next microword address from one of four sources: the incremented address, the target field, the saved return address, or an opcode-derived entry point.

The datapath holds a 16-bit accumulator, a 16-bit data register, and 11-bit address and program-counter registers. It also holds a 2048-word by 16-bit memory. Machine words carry an indirect flag in bit 15, a 4-bit opcode in bits 14:11 and an 11-bit address in bits 10:0. Four operations are supported: accumulate (opcode 0), branch on negative accumulator (opcode 1), store (opcode 2) and swap with memory (opcode 3). Indirect operands are resolved by a shared microcode subroutine at microword 67.

Software loads memory through a write port before reset is released. A combinational peek port reads memory back at any time.

Top module: `acc_ucode_cpu`

## Requirements
- R1: While reset is held, the microword address output is 64 (start of fetch), and the PC and accumulator outputs are 0.
- R2: Each fetch lasts three cycles and raises the PC by one. In the cycle after the fetch, the microword address is the opcode times four.
- R3: Opcode 0 adds the operand word to the accumulator, wrapping modulo 2^16.
- R4: Opcode 1 loads the PC with the effective address when accumulator bit 15 is 1, and otherwise leaves the incremented PC. When the branch is not taken, the indirect flag has no effect.
- R5: Opcode 2 writes the accumulator to memory at the effective address and leaves the accumulator unchanged.
- R6: Opcode 3 swaps the accumulator with the memory word at the effective address. Both transfers of the swap use the values from before the clock edge.
- R7: With bit 15 set, the effective address is bits 10:0 of the memory word at the address field. Otherwise it is the address field itself.
- R8: Cycles from one fetch start to the next are as follows. Opcode 0 takes 6, opcode 2 takes 6 and opcode 3 takes 7. Opcode 1 takes 6 when taken and 5 when not taken. An indirect operand adds 2 to any path that resolves the operand.
- R9: With the load enable high, a clock edge writes the load data to the load address, whether or not reset is held. The peek output shows the memory word at the peek address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Memory preload write enable |
| loadAddr | input | 11 | Preload address |
| loadData | input | 16 | Preload data |
| peekAddr | input | 11 | Memory read-back address |
| peekData | output | 16 | Memory word at peekAddr |
| acOut | output | 16 | Accumulator |
| pcOut | output | 11 | Program counter |
| carOut | output | 7 | Current microword address |

## Verification
The bench steers the program through several corner cases:
- A branch taken on a negative accumulator, and a branch not taken whose indirect flag set must be ignored.
- Accumulation that wraps past 0xFFFF to 0.
- Indirect operands on accumulate, swap, store and taken-branch routines.
- A swap, where a design that updated one register before reading the other would duplicate a value instead of exchanging it.

A faulty opcode mapping shows up as a wrong dispatch address three cycles after fetch starts. A broken call or return link shows up as a wrong cycle count or a wrong operand. A missed PC increment corrupts every later instruction the model follows.

// File: rtl/acc_ucode_pkg.sv
package acc_ucode_pkg;

  localparam int CAR_W  = 7;
  localparam int UW_W   = 20;
  localparam int OPC_W  = 4;
  localparam logic [CAR_W-1:0] FETCH_ORG    = 7'd64;
  localparam logic [CAR_W-1:0] INDIRECT_ORG = 7'd67;

  typedef enum logic [3:0] {
    AC_HOLD, AC_ADD, AC_SUB, AC_OR, AC_AND, AC_XOR,
    AC_CLR, AC_INC, AC_LDDR, AC_COM, AC_SHL, AC_SHR
  } acOpT;

  typedef enum logic [2:0] {DR_HOLD, DR_MEM, DR_AC, DR_INC, DR_PC} drOpT;
  typedef enum logic [1:0] {AR_HOLD, AR_DR, AR_PC} arOpT;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_AR} pcOpT;

  typedef enum logic [1:0] {CD_ALWAYS, CD_IND, CD_SIGN, CD_ZERO} condT;
  typedef enum logic [1:0] {BR_JMP, BR_CALL, BR_RET, BR_MAP} brT;

  typedef struct packed {
    acOpT acOp;
    drOpT drOp;
    arOpT arOp;
    pcOpT pcOp;
    logic memWr;
  } strobeT;

endpackage

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import acc_ucode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             indBit,
  input  logic             acNeg,
  input  logic             acZero,
  input  logic [OPC_W-1:0] opcode,
  output strobeT           strobe,
  output logic [CAR_W-1:0] car
);

  // pack one microword: ops1, ops2, ops3, condition, branch kind, target
  function automatic logic [UW_W-1:0] uw(input logic [2:0] o1, input logic [2:0] o2,
                                         input logic [2:0] o3, input logic [1:0] cd,
                                         input logic [1:0] br, input logic [CAR_W-1:0] ad);
    return {o1, o2, o3, cd, br, ad};
  endfunction

  function automatic logic [UW_W-1:0] romWord(input logic [CAR_W-1:0] a);
    unique case (a)
      // accumulate
      7'd0:  romWord = uw(3'b000, 3'b000, 3'b000, 2'b01, 2'b01, INDIRECT_ORG);
      7'd1:  romWord = uw(3'b000, 3'b100, 3'b000, 2'b00, 2'b00, 7'd2);
      7'd2:  romWord = uw(3'b001, 3'b000, 3'b000, 2'b00, 2'b00, FETCH_ORG);
      // branch if negative
      7'd4:  romWord = uw(3'b000, 3'b000, 3'b000, 2'b10, 2'b00, 7'd6);
      7'd5:  romWord = uw(3'b000, 3'b000, 3'b000, 2'b00, 2'b00, FETCH_ORG);
      7'd6:  romWord = uw(3'b000, 3'b000, 3'b000, 2'b01, 2'b01, INDIRECT_ORG);
      7'd7:  romWord = uw(3'b000, 3'b000, 3'b110, 2'b00, 2'b00, FETCH_ORG);
      // store
      7'd8:  romWord = uw(3'b000, 3'b000, 3'b000, 2'b01, 2'b01, INDIRECT_ORG);
      7'd9:  romWord = uw(3'b000, 3'b101, 3'b000, 2'b00, 2'b00, 7'd10);
      7'd10: romWord = uw(3'b111, 3'b000, 3'b000, 2'b00, 2'b00, FETCH_ORG);
      // swap with memory
      7'd12: romWord = uw(3'b000, 3'b000, 3'b000, 2'b01, 2'b01, INDIRECT_ORG);
      7'd13: romWord = uw(3'b000, 3'b100, 3'b000, 2'b00, 2'b00, 7'd14);
      7'd14: romWord = uw(3'b100, 3'b101, 3'b000, 2'b00, 2'b00, 7'd15);
      7'd15: romWord = uw(3'b111, 3'b000, 3'b000, 2'b00, 2'b00, FETCH_ORG);
      // fetch
      7'd64: romWord = uw(3'b110, 3'b000, 3'b000, 2'b00, 2'b00, 7'd65);
      7'd65: romWord = uw(3'b000, 3'b100, 3'b101, 2'b00, 2'b00, 7'd66);
      7'd66: romWord = uw(3'b101, 3'b000, 3'b000, 2'b00, 2'b11, 7'd0);
      // operand indirection subroutine
      7'd67: romWord = uw(3'b000, 3'b100, 3'b000, 2'b00, 2'b00, 7'd68);
      7'd68: romWord = uw(3'b101, 3'b000, 3'b000, 2'b00, 2'b10, 7'd0);
      default: romWord = uw(3'b000, 3'b000, 3'b000, 2'b00, 2'b00, FETCH_ORG);
    endcase
  endfunction

  logic [UW_W-1:0]  uword;
  logic [2:0]       ops1, ops2, ops3;
  condT             cdSel;
  brT               brKind;
  logic [CAR_W-1:0] target, sbr, carInc, carNext, mapAddr;
  logic             condTrue;

  assign uword   = romWord(car);
  assign ops1    = uword[19:17];
  assign ops2    = uword[16:14];
  assign ops3    = uword[13:11];
  assign cdSel   = condT'(uword[10:9]);
  assign brKind  = brT'(uword[8:7]);
  assign target  = uword[6:0];
  assign carInc  = car + 1'b1;
  assign mapAddr = {{(CAR_W-OPC_W-2){1'b0}}, opcode, 2'b00};

  always_comb begin
    unique case (cdSel)
      CD_ALWAYS: condTrue = 1'b1;
      CD_IND:    condTrue = indBit;
      CD_SIGN:   condTrue = acNeg;
      CD_ZERO:   condTrue = acZero;
    endcase
  end

  always_comb begin
    unique case (brKind)
      BR_JMP, BR_CALL: carNext = condTrue ? target : carInc;
      BR_RET:          carNext = sbr;
      BR_MAP:          carNext = mapAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      car <= FETCH_ORG;
      sbr <= '0;
    end else begin
      car <= carNext;
      if (brKind == BR_CALL && condTrue) sbr <= carInc;
    end
  end

  // field decode; later fields take the accumulator when two name it
  always_comb begin
    strobe = '{acOp: AC_HOLD, drOp: DR_HOLD, arOp: AR_HOLD, pcOp: PC_HOLD, memWr: 1'b0};
    case (ops1)
      3'b001: strobe.acOp  = AC_ADD;
      3'b010: strobe.acOp  = AC_CLR;
      3'b011: strobe.acOp  = AC_INC;
      3'b100: strobe.acOp  = AC_LDDR;
      3'b101: strobe.arOp  = AR_DR;
      3'b110: strobe.arOp  = AR_PC;
      3'b111: strobe.memWr = 1'b1;
      default: ;
    endcase
    case (ops2)
      3'b001: strobe.acOp = AC_SUB;
      3'b010: strobe.acOp = AC_OR;
      3'b011: strobe.acOp = AC_AND;
      3'b100: strobe.drOp = DR_MEM;
      3'b101: strobe.drOp = DR_AC;
      3'b110: strobe.drOp = DR_INC;
      3'b111: strobe.drOp = DR_PC;
      default: ;
    endcase
    case (ops3)
      3'b001: strobe.acOp = AC_XOR;
      3'b010: strobe.acOp = AC_COM;
      3'b011: strobe.acOp = AC_SHL;
      3'b100: strobe.acOp = AC_SHR;
      3'b101: strobe.pcOp = PC_INC;
      3'b110: strobe.pcOp = PC_AR;
      default: ;
    endcase
  end

  // R2: opcode dispatch lands on opcode*4
  a_r2_map_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == BR_MAP) |=> (car == {{(CAR_W-OPC_W-2){1'b0}}, $past(opcode), 2'b00}));

  // R7: a taken call links the following microword and jumps to the target
  a_r7_call_link: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == BR_CALL && condTrue) |=> (sbr == $past(car) + 1'b1 && car == $past(target)));

  // R7: return resumes at the linked address
  a_r7_return: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == BR_RET) |=> (car == $past(sbr)));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_ucode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              loadEn,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [MEM_AW-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] acQ,
  output logic [MEM_AW-1:0] pcQ,
  output logic              indBit,
  output logic [OPC_W-1:0]  opcode,
  output logic              acNeg,
  output logic              acZero
);

  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [0:MEM_DEPTH-1];
  logic [DATA_W-1:0] ac, dr, acNext, drNext, memRd;
  logic [MEM_AW-1:0] ar, pc, arNext, pcNext;

  assign memRd    = mem[ar];
  assign peekData = mem[peekAddr];
  assign acQ      = ac;
  assign pcQ      = pc;
  assign indBit   = dr[DATA_W-1];
  assign opcode   = dr[DATA_W-2 -: OPC_W];
  assign acNeg    = ac[DATA_W-1];
  assign acZero   = (ac == '0);

  // every source below is a pre-edge register value
  always_comb begin
    unique case (strobe.acOp)
      AC_ADD:  acNext = ac + dr;
      AC_SUB:  acNext = ac - dr;
      AC_OR:   acNext = ac | dr;
      AC_AND:  acNext = ac & dr;
      AC_XOR:  acNext = ac ^ dr;
      AC_CLR:  acNext = '0;
      AC_INC:  acNext = ac + DATA_W'(1);
      AC_LDDR: acNext = dr;
      AC_COM:  acNext = ~ac;
      AC_SHL:  acNext = ac << 1;
      AC_SHR:  acNext = ac >> 1;
      default: acNext = ac;
    endcase
    unique case (strobe.drOp)
      DR_MEM:  drNext = memRd;
      DR_AC:   drNext = ac;
      DR_INC:  drNext = dr + DATA_W'(1);
      DR_PC:   drNext = {dr[DATA_W-1:MEM_AW], pc};
      default: drNext = dr;
    endcase
    unique case (strobe.arOp)
      AR_DR:   arNext = dr[MEM_AW-1:0];
      AR_PC:   arNext = pc;
      default: arNext = ar;
    endcase
    unique case (strobe.pcOp)
      PC_INC:  pcNext = pc + MEM_AW'(1);
      PC_AR:   pcNext = ar;
      default: pcNext = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ac <= '0;
      dr <= '0;
      ar <= '0;
      pc <= '0;
    end else begin
      ac <= acNext;
      dr <= drNext;
      ar <= arNext;
      pc <= pcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn)            mem[loadAddr] <= loadData;
    else if (strobe.memWr) mem[ar]       <= dr;
  end

  // R2: the fetch increment advances the PC by exactly one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pcOp == PC_INC) |=> (pc == $past(pc) + MEM_AW'(1)));

  // R3: accumulation wraps modulo 2^DATA_W
  a_r3_add_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.acOp == AC_ADD) |=> (ac == DATA_W'($past(ac) + $past(dr))));

  // R6: swap takes both old values
  a_r6_swap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.acOp == AC_LDDR && strobe.drOp == DR_AC) |=> (ac == $past(dr) && dr == $past(ac)));

  // R2: the address register follows the PC at fetch start
  a_r2_ar_from_pc: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arOp == AR_PC) |=> (ar == $past(pc)));

endmodule

// File: rtl/acc_ucode_cpu.sv
module acc_ucode_cpu
  import acc_ucode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [MEM_AW-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] acOut,
  output logic [MEM_AW-1:0] pcOut,
  output logic [CAR_W-1:0]  carOut
);

  strobeT           strobe;
  logic             indBit, acNeg, acZero;
  logic [OPC_W-1:0] opcode;

  ucode_sequencer uSeq (
    .clk    (clk),
    .rstN   (rstN),
    .indBit (indBit),
    .acNeg  (acNeg),
    .acZero (acZero),
    .opcode (opcode),
    .strobe (strobe),
    .car    (carOut)
  );

  acc_datapath #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .peekAddr (peekAddr),
    .peekData (peekData),
    .acQ      (acOut),
    .pcQ      (pcOut),
    .indBit   (indBit),
    .opcode   (opcode),
    .acNeg    (acNeg),
    .acZero   (acZero)
  );

endmodule

// File: tb/tb_acc_ucode_cpu.sv
module tb_acc_ucode_cpu;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 11;
  localparam int N_INSTR = 16;
  localparam int WD_LIMIT = 2000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [DW-1:0] loadData = '0;
  logic [AW-1:0] peekAddr = '0;
  logic [DW-1:0] peekData, acOut;
  logic [AW-1:0] pcOut;
  logic [6:0]    carOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_ucode_cpu #(.DATA_W(DW), .MEM_AW(AW)) dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .peekAddr(peekAddr), .peekData(peekData), .acOut(acOut), .pcOut(pcOut), .carOut(carOut)
  );

  int checks = 0;
  int errors = 0;

  // instruction-level reference state
  logic [DW-1:0] mdl [0:2047];
  logic [DW-1:0] mAc;
  logic [AW-1:0] mPc;
  int            expLen, expCar;
  string         tag;
  logic          memTouched;
  logic [AW-1:0] lastEa;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(input logic ind, input int op, input int a);
    return {ind, op[3:0], a[10:0]};
  endfunction

  task automatic put(input int a, input logic [DW-1:0] d);
    mdl[a] = d;
    @(negedge clk);
    loadEn = 1'b1;
    loadAddr = a[AW-1:0];
    loadData = d;
  endtask

  task automatic step();
    logic [DW-1:0] instr, tmp;
    logic          ind;
    int            op, extra;
    logic [AW-1:0] a, ea;
    instr = mdl[mPc];
    mPc = mPc + 1'b1;
    ind = instr[15];
    op = int'(instr[14:11]);
    a = instr[10:0];
    ea = ind ? mdl[a][10:0] : a;
    extra = ind ? 2 : 0;
    expCar = op * 4;
    memTouched = 1'b0;
    case (op)
      0: begin mAc = mAc + mdl[ea]; expLen = 6 + extra; tag = "R3"; end
      1: begin
        tag = "R4";
        if (mAc[15]) begin mPc = ea; expLen = 6 + extra; end
        else begin expLen = 5; ind = 1'b0; end
      end
      2: begin mdl[ea] = mAc; expLen = 6 + extra; memTouched = 1'b1; lastEa = ea; tag = "R5"; end
      3: begin
        tmp = mdl[ea]; mdl[ea] = mAc; mAc = tmp;
        expLen = 7 + extra; memTouched = 1'b1; lastEa = ea; tag = "R6";
      end
      default: begin expLen = 0; tag = "R8"; end
    endcase
    if (ind) tag = {tag, "/R7"};
  endtask

  initial begin
    int since, done, cyc;
    logic pending;
    for (int k = 0; k < 2048; k++) mdl[k] = '0;

    // program
    put(0,  enc(0, 0, 100));
    put(1,  enc(0, 0, 101));
    put(2,  enc(0, 1, 5));
    put(3,  enc(0, 0, 100));
    put(5,  enc(0, 2, 110));
    put(6,  enc(0, 3, 102));
    put(7,  enc(1, 1, 103));   // not taken, indirect flag must be ignored
    put(8,  enc(1, 0, 104));
    put(9,  enc(1, 3, 106));
    put(10, enc(0, 0, 108));   // wraps to zero
    put(11, enc(0, 3, 109));
    put(12, enc(1, 1, 111));
    put(14, enc(1, 2, 112));
    put(15, enc(0, 0, 100));
    put(16, enc(0, 1, 16));
    // data
    put(100, 16'h7FFF);
    put(101, 16'h0003);
    put(102, 16'h1234);
    put(103, 16'h0003);
    put(104, 16'd105);
    put(105, 16'hF000);
    put(106, 16'd107);
    put(107, 16'hFFFF);
    put(108, 16'h0001);
    put(109, 16'h8000);
    put(111, 16'd14);
    put(112, 16'd113);
    @(negedge clk);
    loadEn = 1'b0;

    peekAddr = 11'd100;
    #1;
    check("R9", "preload peek", peekData, 16'h7FFF);
    check("R1", "reset car", carOut, 64);
    check("R1", "reset pc", pcOut, 0);
    check("R1", "reset ac", acOut, 0);

    mAc = '0;
    mPc = '0;
    pending = 1'b0;
    since = 0;
    done = 0;
    cyc = 0;
    @(negedge clk);
    rstN = 1'b1;
    while (done < N_INSTR && cyc < WD_LIMIT) begin
      #1;
      if (pending && since == 3) check("R2", "dispatch address", carOut, expCar);
      if (carOut == 7'd64) begin
        if (pending) begin
          check("R8", "instruction cycles", since, expLen);
          check(tag, "pc", pcOut, mPc);
          check(tag, "ac", acOut, mAc);
          if (memTouched) begin
            peekAddr = lastEa;
            #1;
            check(tag, "memory word", peekData, mdl[lastEa]);
          end
          done++;
        end
        step();
        pending = 1'b1;
        since = 0;
      end
      since++;
      cyc++;
      @(negedge clk);
    end
    if (cyc >= WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual %0d instructions expected %0d", done, N_INSTR);
    end

    for (int k = 100; k <= 113; k++) begin
      peekAddr = k[AW-1:0];
      #1;
      check("R5/R6", "final memory", peekData, mdl[k]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule